// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the programming state of four DMA channels. Each channel has a source address, a destination address, a transfer count and a control word. A single write port carries a channel index, a register select and a 32-bit data word. Every write goes through a per-channel filter before it is stored. Addresses are trimmed and checked against memory-region limits, and an illegal address is dropped without any trace. A zero count becomes the channel's largest transfer size. Control bits that do not exist on a channel are forced to zero.

When a channel's enable bit goes from clear to set, the block copies that channel's source and destination into a pair of working address registers. In the same cycle it raises a one-cycle start pulse for the transfer engine. The engine can later drop the enable bit through a per-channel clear input. A registered read port returns the value that was actually kept, so software sees the result of any filtering. Moving the data and arbitrating between channels are the engine's job and are not part of this block.

Top module: `dmach_regfile`

## Requirements
- R1: A written source or destination address is reduced to its low 28 bits with bit 0 forced to 0 (data AND 0x0FFFFFFE) before any legality test.
- R2: A source address is stored only if it is at or above 0x02000000. Channel 0 also refuses any source in the range 0x08000000 up to but not including 0x0E000000.
- R3: Channel 3 accepts a destination address anywhere. Channels 0 to 2 accept a destination only below 0x08000000.
- R4: A refused address write leaves the previous register contents unchanged, and reading the register back returns that retained value.
- R5: A count write uses data bits 15:0. A value of zero stores 0x10000 on channel 3 and 0x4000 on channels 0 to 2. Any other value is stored unchanged.
- R6: After a synchronous reset, every address, working address and control register is zero. Channels 0 to 2 hold count 0x4000, channel 3 holds count 0x10000, and no start pulse is present.
- R7: A control write stores data bits 15:0 ANDed with 0xF7E0 on channels 0 to 2 and with 0xFFE0 on channel 3. Bit 15 is the enable bit.
- R8: A control write that takes the enable bit from 0 to 1 copies the stored source and destination into that channel's working registers. It also drives that channel's bit of `start_o` high for exactly the one cycle after the write edge. At most one start bit is high at a time.
- R9: A control write to a channel whose enable bit is already set leaves the working registers unchanged and raises no start pulse.
- R10: A high `clr_en_i` bit clears that channel's enable bit. If a control write to the same channel arrives in the same cycle, the clear is applied first, so a written enable counts as a fresh 0-to-1 transition.
- R11: `rd_data_o` is registered. One cycle after `rd_ch_i`/`rd_sel_i` are presented, it shows the selected register's contents from before that edge, zero-extended. The select codes are 0 = source, 1 = destination, 2 = count, 3 = control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| wr_ch_i | input | CH_W | Channel index for the write |
| wr_sel_i | input | 2 | Register select for the write (0 src, 1 dst, 2 count, 3 control) |
| wr_data_i | input | DATA_W | Write data |
| clr_en_i | input | NCH | Per-channel enable clear from the transfer engine |
| rd_ch_i | input | CH_W | Channel index for the read |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | DATA_W | Registered read-back of the kept value |
| start_o | output | NCH | One-cycle start pulse per channel |
| work_src_o | output | NCH*ADDR_W | Latched working source address per channel |
| work_dst_o | output | NCH*ADDR_W | Latched working destination address per channel |
| cnt_o | output | NCH*CNT_W | Stored count per channel |
| ctl_o | output | NCH*CTL_W | Stored control word per channel |

## Verification
Two things can land on one channel in the same cycle: the engine's enable clear and a software control write. The bench creates this by holding a channel enabled, then asserting `clr_en_i` for that channel in the same cycle as a control write that sets the enable bit. Because the clear is applied first, the expected result is a start pulse on the next cycle and working registers loaded from the newly programmed source. The bench also covers the case where a clear arrives alone and the case where a rewrite happens while the channel is still enabled. A reference model checks every output on every clock.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_CNT = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  localparam int CNT_FIELD_W = 16;
endpackage

// File: rtl/dmach_addr_gate.sv
module dmach_addr_gate #(
  parameter int          ADDR_W    = 28,
  parameter bit          IS_FIRST  = 1'b0,
  parameter bit          IS_FULL   = 1'b0,
  parameter logic [31:0] WRAM_BASE = 32'h0200_0000,
  parameter logic [31:0] CART_BASE = 32'h0800_0000,
  parameter logic [31:0] SRAM_BASE = 32'h0E00_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              src_ok_o,
  output logic              dst_ok_o
);
  localparam logic [ADDR_W-1:0] WB = WRAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] CB = CART_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SB = SRAM_BASE[ADDR_W-1:0];

  logic above_wram;
  logic in_rom;
  assign above_wram = (addr_i >= WB);
  assign in_rom     = (addr_i >= CB) && (addr_i < SB);

  generate
    if (IS_FIRST) begin : g_src_first
      assign src_ok_o = above_wram && !in_rom;
    end else begin : g_src_other
      assign src_ok_o = above_wram;
    end
    if (IS_FULL) begin : g_dst_full
      assign dst_ok_o = 1'b1;
    end else begin : g_dst_low
      assign dst_ok_o = (addr_i < CB);
    end
  endgenerate
endmodule

// File: rtl/dmach_chan.sv
module dmach_chan
  import dmach_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 28,
  parameter int          CNT_W     = 17,
  parameter int          CTL_W     = 16,
  parameter bit          IS_FIRST  = 1'b0,
  parameter bit          IS_FULL   = 1'b0,
  parameter logic [31:0] WRAM_BASE = 32'h0200_0000,
  parameter logic [31:0] CART_BASE = 32'h0800_0000,
  parameter logic [31:0] SRAM_BASE = 32'h0E00_0000,
  parameter logic [CTL_W-1:0] CTL_MASK = 16'hF7E0,
  parameter int          CNT_MAX   = 16384
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_src_i,
  input  logic              we_dst_i,
  input  logic              we_cnt_i,
  input  logic              we_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [ADDR_W-1:0] wsrc_o,
  output logic [ADDR_W-1:0] wdst_o,
  output logic              start_o
);
  localparam int               EN_BIT   = CTL_W - 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_MAX[CNT_W-1:0];

  logic [ADDR_W-1:0] src_q, dst_q, wsrc_q, wdst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              start_q;

  logic [ADDR_W-1:0] addr_trim;
  logic              src_ok, dst_ok;
  logic [CTL_W-1:0]  ctl_new;
  logic              en_live;
  logic [CNT_FIELD_W-1:0] cnt_field;
  logic              unused_bits;

  assign addr_trim   = {wdata_i[ADDR_W-1:1], 1'b0};
  assign ctl_new     = wdata_i[CTL_W-1:0] & CTL_MASK;
  assign cnt_field   = wdata_i[CNT_FIELD_W-1:0];
  assign en_live     = ctl_q[EN_BIT] && !clr_i;
  assign unused_bits = ^{wdata_i[DATA_W-1:ADDR_W], wdata_i[0]};

  dmach_addr_gate #(
    .ADDR_W(ADDR_W), .IS_FIRST(IS_FIRST), .IS_FULL(IS_FULL),
    .WRAM_BASE(WRAM_BASE), .CART_BASE(CART_BASE), .SRAM_BASE(SRAM_BASE)
  ) gate_i (
    .addr_i(addr_trim), .src_ok_o(src_ok), .dst_ok_o(dst_ok)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src_q   <= '0;
      dst_q   <= '0;
      wsrc_q  <= '0;
      wdst_q  <= '0;
      cnt_q   <= CNT_FULL;
      ctl_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (clr_i) ctl_q[EN_BIT] <= 1'b0;
      if (we_ctl_i) begin
        ctl_q <= ctl_new;
        if (!en_live && ctl_new[EN_BIT]) begin
          wsrc_q  <= src_q;
          wdst_q  <= dst_q;
          start_q <= 1'b1;
        end
      end
      if (we_src_i && src_ok) src_q <= addr_trim;
      if (we_dst_i && dst_ok) dst_q <= addr_trim;
      if (we_cnt_i)
        cnt_q <= (cnt_field == '0) ? CNT_FULL : CNT_W'(cnt_field);
    end
  end

  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign ctl_o   = ctl_q;
  assign wsrc_o  = wsrc_q;
  assign wdst_o  = wdst_q;
  assign start_o = start_q;

  // R5: stored count is never zero
  assert_count_nonzero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q != '0);
  // R2: kept source is either reset value or at/above the working-RAM base
  assert_src_floor_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_q == '0) || (src_q >= WRAM_BASE[ADDR_W-1:0]));
  // R7: low control bits never stored
  assert_ctl_low_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ctl_q[4:0] == 5'd0);
  // R8: a start pulse coincides with an enabled channel
  assert_start_enabled_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    start_q |-> ctl_q[EN_BIT]);
  // R8: working registers move only together with a start pulse
  assert_work_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(wsrc_q) |-> start_q);
  // R9: rewriting an enabled channel does not restart it
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_q[EN_BIT] && we_ctl_i && !clr_i) |=> !start_q);
  // R10: a lone clear drops the enable bit
  assert_clear_drops_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !we_ctl_i) |=> !ctl_q[EN_BIT]);
endmodule

// File: rtl/dmach_readmux.sv
module dmach_readmux
  import dmach_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 17,
  parameter int CTL_W  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic [CH_W-1:0]              rd_ch_i,
  input  logic [1:0]                   rd_sel_i,
  input  logic [NCH-1:0][ADDR_W-1:0]   src_i,
  input  logic [NCH-1:0][ADDR_W-1:0]   dst_i,
  input  logic [NCH-1:0][CNT_W-1:0]    cnt_i,
  input  logic [NCH-1:0][CTL_W-1:0]    ctl_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    case (reg_sel_e'(rd_sel_i))
      SEL_SRC: pick = DATA_W'(src_i[rd_ch_i]);
      SEL_DST: pick = DATA_W'(dst_i[rd_ch_i]);
      SEL_CNT: pick = DATA_W'(cnt_i[rd_ch_i]);
      default: pick = DATA_W'(ctl_i[rd_ch_i]);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_o <= '0;
    else       rd_data_o <= pick;
  end
endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile
  import dmach_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 28,
  parameter int          CNT_W     = 17,
  parameter int          CTL_W     = 16,
  parameter logic [31:0] WRAM_BASE = 32'h0200_0000,
  parameter logic [31:0] CART_BASE = 32'h0800_0000,
  parameter logic [31:0] SRAM_BASE = 32'h0E00_0000,
  parameter logic [CTL_W-1:0] MASK_SHORT = 16'hF7E0,
  parameter logic [CTL_W-1:0] MASK_FULL  = 16'hFFE0,
  parameter int          MAX_SHORT = 16384,
  parameter int          MAX_FULL  = 65536,
  localparam int         CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [1:0]              wr_sel_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [NCH-1:0]          clr_en_i,
  input  logic [CH_W-1:0]         rd_ch_i,
  input  logic [1:0]              rd_sel_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [NCH-1:0]          start_o,
  output logic [NCH*ADDR_W-1:0]   work_src_o,
  output logic [NCH*ADDR_W-1:0]   work_dst_o,
  output logic [NCH*CNT_W-1:0]    cnt_o,
  output logic [NCH*CTL_W-1:0]    ctl_o
);
  logic [NCH-1:0][ADDR_W-1:0] src_a, dst_a, wsrc_a, wdst_a;
  logic [NCH-1:0][CNT_W-1:0]  cnt_a;
  logic [NCH-1:0][CTL_W-1:0]  ctl_a;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (wr_ch_i == CH_W'(c));

    dmach_chan #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(CTL_W),
      .IS_FIRST(c == 0), .IS_FULL(c == NCH - 1),
      .WRAM_BASE(WRAM_BASE), .CART_BASE(CART_BASE), .SRAM_BASE(SRAM_BASE),
      .CTL_MASK((c == NCH - 1) ? MASK_FULL : MASK_SHORT),
      .CNT_MAX((c == NCH - 1) ? MAX_FULL : MAX_SHORT)
    ) chan_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .we_src_i(hit && (wr_sel_i == SEL_SRC)),
      .we_dst_i(hit && (wr_sel_i == SEL_DST)),
      .we_cnt_i(hit && (wr_sel_i == SEL_CNT)),
      .we_ctl_i(hit && (wr_sel_i == SEL_CTL)),
      .wdata_i (wr_data_i),
      .clr_i   (clr_en_i[c]),
      .src_o   (src_a[c]),
      .dst_o   (dst_a[c]),
      .cnt_o   (cnt_a[c]),
      .ctl_o   (ctl_a[c]),
      .wsrc_o  (wsrc_a[c]),
      .wdst_o  (wdst_a[c]),
      .start_o (start_o[c])
    );
  end

  assign work_src_o = wsrc_a;
  assign work_dst_o = wdst_a;
  assign cnt_o      = cnt_a;
  assign ctl_o      = ctl_a;

  dmach_readmux #(
    .NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CTL_W(CTL_W)
  ) rmux_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rd_ch_i  (rd_ch_i),
    .rd_sel_i (rd_sel_i),
    .src_i    (src_a),
    .dst_i    (dst_a),
    .cnt_i    (cnt_a),
    .ctl_i    (ctl_a),
    .rd_data_o(rd_data_o)
  );

  // R8: one write port means at most one start pulse per cycle
  assert_single_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(start_o));
  // R8: a start pulse follows a control write edge
  assert_start_after_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_o != '0) |-> $past(wr_en_i && (wr_sel_i == SEL_CTL)));
endmodule

// File: tb/dmach_regfile_tb_top.sv
module dmach_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0, wr_sel = '0, rd_ch = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  clr_en = '0;
  logic [31:0] rd_data;
  logic [3:0]  start;
  logic [111:0] wsrc, wdst;
  logic [67:0]  cnt;
  logic [63:0]  ctl;

  always #4 clk = ~clk;

  dmach_regfile dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .clr_en_i(clr_en),
    .rd_ch_i(rd_ch), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .start_o(start), .work_src_o(wsrc), .work_dst_o(wdst),
    .cnt_o(cnt), .ctl_o(ctl)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R6";

  logic [31:0] m_src[4], m_dst[4], m_cnt[4], m_ctl[4], m_ws[4], m_wd[4];
  logic [31:0] e_rd;
  logic [3:0]  e_start;

  task automatic m_reset();
    for (int c = 0; c < 4; c++) begin
      m_src[c] = 0; m_dst[c] = 0; m_ctl[c] = 0; m_ws[c] = 0; m_wd[c] = 0;
      m_cnt[c] = (c == 3) ? 32'h10000 : 32'h4000;
    end
    e_rd = 0; e_start = 0;
  endtask

  task automatic m_step();
    logic [31:0] a, nv;
    bit en_old;
    case (rd_sel)
      2'd0: e_rd = m_src[rd_ch];
      2'd1: e_rd = m_dst[rd_ch];
      2'd2: e_rd = m_cnt[rd_ch];
      default: e_rd = m_ctl[rd_ch];
    endcase
    e_start = 0;
    for (int c = 0; c < 4; c++) begin
      en_old = m_ctl[c][15] && !clr_en[c];
      if (clr_en[c]) m_ctl[c][15] = 1'b0;
      if (wr_en && wr_ch == c) begin
        a = wr_data & 32'h0FFF_FFFE;
        case (wr_sel)
          2'd0: if (a >= 32'h0200_0000 &&
                    !(c == 0 && a >= 32'h0800_0000 && a < 32'h0E00_0000)) m_src[c] = a;
          2'd1: if (c == 3 || a < 32'h0800_0000) m_dst[c] = a;
          2'd2: m_cnt[c] = (wr_data[15:0] == 0) ? ((c == 3) ? 32'h10000 : 32'h4000)
                                               : {16'h0, wr_data[15:0]};
          default: begin
            nv = wr_data & ((c == 3) ? 32'hFFE0 : 32'hF7E0);
            if (!en_old && nv[15]) begin
              m_ws[c] = m_src[c]; m_wd[c] = m_dst[c]; e_start[c] = 1'b1;
            end
            m_ctl[c] = nv;
          end
        endcase
      end
    end
  endtask

  task automatic compare();
    logic [111:0] xs, xd;
    logic [67:0]  xc;
    logic [63:0]  xl;
    for (int c = 0; c < 4; c++) begin
      xs[c*28 +: 28] = m_ws[c][27:0];
      xd[c*28 +: 28] = m_wd[c][27:0];
      xc[c*17 +: 17] = m_cnt[c][16:0];
      xl[c*16 +: 16] = m_ctl[c][15:0];
    end
    n_chk++;
    if (rd_data !== e_rd || start !== e_start || wsrc !== xs || wdst !== xd ||
        cnt !== xc || ctl !== xl) begin
      n_err++;
      $display("FAIL %s model: rd=%h/%h start=%b/%b ws=%h/%h ctl=%h/%h (actual/expected)",
               cur_req, rd_data, e_rd, start, e_start, wsrc, xs, ctl, xl);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rst) m_reset(); else m_step();
    @(negedge clk);
    compare();
  endtask

  task automatic lit(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s literal: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel);
    rd_ch = 2'(ch); rd_sel = 2'(sel);
    cycle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    // R6 reset defaults
    cur_req = "R6";
    rd(0, 2); rd(0, 2); lit(rd_data, 32'h4000, "R6 ch0 cnt");
    rd(3, 2); lit(rd_data, 32'h10000, "R6 ch3 cnt");
    rd(2, 0); lit(rd_data, 0, "R6 ch2 src");
    lit({28'h0, start}, 0, "R6 start");
    // R1 trimming
    cur_req = "R1";
    wr(1, 0, 32'h1234_5677); rd(1, 0); lit(rd_data, 32'h0234_5676, "R1 ch1 src");
    // R2 / R4 source legality and retention
    cur_req = "R4";
    wr(1, 0, 32'h0100_0000); rd(1, 0); lit(rd_data, 32'h0234_5676, "R4 ch1 src kept");
    cur_req = "R2";
    wr(0, 0, 32'h0800_1000); rd(0, 0); lit(rd_data, 0, "R2 ch0 rom refused");
    wr(0, 0, 32'h0E00_0010); rd(0, 0); lit(rd_data, 32'h0E00_0010, "R2 ch0 sram ok");
    wr(1, 0, 32'h0800_1000); rd(1, 0); lit(rd_data, 32'h0800_1000, "R2 ch1 rom ok");
    // R3 destination legality
    cur_req = "R3";
    wr(2, 1, 32'h07FF_FFFF); wr(2, 1, 32'h0800_0000);
    rd(2, 1); lit(rd_data, 32'h07FF_FFFE, "R3 ch2 dst");
    wr(3, 1, 32'h0D00_0000); rd(3, 1); lit(rd_data, 32'h0D00_0000, "R3 ch3 dst");
    wr(1, 1, 32'h0300_0040);
    // R5 count
    cur_req = "R5";
    wr(2, 2, 0); rd(2, 2); lit(rd_data, 32'h4000, "R5 ch2 zero");
    wr(3, 2, 32'h5); wr(3, 2, 0); rd(3, 2); lit(rd_data, 32'h10000, "R5 ch3 zero");
    wr(0, 2, 32'hABCD_0007); rd(0, 2); lit(rd_data, 32'h7, "R5 ch0 field");
    // R7 control mask
    cur_req = "R7";
    wr(0, 3, 32'hFFFF_7FFF); rd(0, 3); lit(rd_data, 32'h77E0, "R7 ch0 ctl");
    wr(3, 3, 32'h7FFF); rd(3, 3); lit(rd_data, 32'h7FE0, "R7 ch3 ctl");
    // R8 enable edge
    cur_req = "R8";
    wr(1, 3, 32'h8000);
    lit({28'h0, start}, 32'h2, "R8 start ch1");
    lit({4'h0, wsrc[55:28]}, 32'h0800_1000, "R8 work src");
    lit({4'h0, wdst[55:28]}, 32'h0300_0040, "R8 work dst");
    cycle(); lit({28'h0, start}, 0, "R8 pulse width");
    // R9 rewrite while enabled
    cur_req = "R9";
    wr(1, 0, 32'h0300_0000); wr(1, 3, 32'h8400);
    lit({28'h0, start}, 0, "R9 no start");
    lit({4'h0, wsrc[55:28]}, 32'h0800_1000, "R9 work kept");
    // R10 clear, alone and with a same-cycle write
    cur_req = "R10";
    clr_en = 4'b0010; cycle(); clr_en = 0;
    rd(1, 3); lit(rd_data, 32'h0400, "R10 cleared");
    wr(1, 3, 32'h8000); cycle();
    clr_en = 4'b0010; wr(1, 3, 32'h8000); clr_en = 0;
    lit({28'h0, start}, 32'h2, "R10 same-cycle start");
    lit({4'h0, wsrc[55:28]}, 32'h0300_0000, "R10 new work src");
    // R11 read select encodings after sweep
    cur_req = "R11";
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 4; s++) rd(c, s);
    rd(2, 1); lit(rd_data, 32'h07FF_FFFE, "R11 sel1 dst");
    cycle(); cycle();
    finish_run();
  end
endmodule